// File: doc/BRIEF.md
# MDIO Management Frame Master

This block carries out one clause-22 style PHY management transaction each time it receives a start request. The caller supplies the direction (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block generates the management clock from the system clock. Each MDC phase lasts a programmable number of system clocks. The block drives the data line through separate output, output-enable and input pins, so the pad and its tri-state buffer sit outside.

A frame starts with a driven preamble of ones. Start, opcode and the two address fields follow. Next comes a turnaround, then sixteen data bits, then a short released tail. On a read, the master lets go of the line at the turnaround and shifts the PHY's data in, MSB first. It then gives three released clocks and an extra low-held end phase before it reports completion. On a write, the master drives every bit up to the end of the data field, then gives one released clock whose sampled value is thrown away. `busy` stays high for the whole frame, and `done` pulses once when the frame ends.

Top module: `mdio_master`

## Requirements
- R1: During and after a synchronous active-high reset, `mdc` is 0, `mdio_oe` is 0, `busy` and `done` are 0, and `rdata` is 0. While idle, `mdc` and `mdio_oe` stay low.
- R2: For the first 32 MDC rising edges of every frame (rises 0 to 31), `mdio_oe` is 1 and `mdio_o` is 1.
- R3: At rises 32 to 45 the master drives, MSB first, the 14-bit header {01, opcode, PHY address[4:0], register address[4:0]}. The opcode is 10 for a read and 01 for a write.
- R4: On a write, rise 46 carries 1 and rise 47 carries 0, both driven. Rises 48 to 63 then carry `wdata[15]` down to `wdata[0]`, driven.
- R5: On a read, `mdio_oe` is 0 from rise 46 to the end of the frame, and the level at rise 47 is ignored. The levels at rises 48 to 63 become `rdata[15]` down to `rdata[0]`.
- R6: A read frame has exactly 67 MDC rises. The last three are released idle clocks. After the final fall, MDC stays low for one half-period (`HALF_CLKS` clocks) and `done` then rises.
- R7: A write frame has exactly 65 MDC rises, and the last one is released. The level sampled there is ignored, so `rdata` keeps its previous value. `done` rises on the same clock edge as the last MDC fall.
- R8: `mdio_o` and `mdio_oe` change only while MDC is low. They hold steady across every MDC high phase.
- R9: A start request that arrives while `busy` is high is ignored. The frame in flight continues unchanged, and no extra frame or `done` follows.
- R10: `done` is high for exactly one clock per frame, and `busy` is low in that clock. `busy` is high for 130·`HALF_CLKS` clocks for a write and 135·`HALF_CLKS` clocks for a read.
- R11: Every MDC high phase lasts exactly `HALF_CLKS` system clocks.
- R12: `rdata` changes only in the clock where `done` ends a read. It keeps its value between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one frame (taken only when idle) |
| op_read | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Data to write |
| rdata | output | 16 | Data returned by the last read |
| done | output | 1 | One-clock pulse at the end of a frame |
| busy | output | 1 | High while a frame is in flight |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A slot counter that is off by one would show up at the pins on the very next MDC rise. It shifts the header or data bits by one position, or it changes the number of rises counted per frame, and both are checked bit by bit against a frame built independently in the bench. A wrong tail phase would change the fall-to-`done` gap or the length of `busy`, so it is visible within one half-period of the frame's end. A bad capture position or a missing release would corrupt `rdata` or `mdio_oe` during that same frame. A stale or leaking capture would appear in `rdata` when the next frame finishes.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        op_read,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        done,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CW       = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam int PRE_LEN  = 32;
  localparam int TA_SLOT  = PRE_LEN + 14;
  localparam int DAT_SLOT = TA_SLOT + 2;
  localparam int DAT_END  = DAT_SLOT + 15;
  localparam int WR_LAST  = DAT_END + 1;
  localparam int RD_LAST  = DAT_END + 3;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_END} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [6:0]    slot;
  logic          rd;
  logic [31:0]   frame;
  logic [15:0]   rx;

  wire       half_up = (cnt == CW'(HALF_CLKS - 1));
  wire [6:0] nslot   = slot + 7'd1;
  wire [6:0] last    = rd ? 7'(RD_LAST) : 7'(WR_LAST);
  wire       cap_win = rd && (slot >= 7'(DAT_SLOT)) && (slot <= 7'(DAT_END));
  wire [31:0] frame_in = {2'b01, (op_read ? 2'b10 : 2'b01), phy_addr, reg_addr, 2'b10, wdata};

  assign busy = (st != S_IDLE);

  function automatic logic [1:0] drive(input logic [6:0] n, input logic r, input logic [31:0] f);
    if (n < 7'(PRE_LEN)) return 2'b11;
    if (n < (r ? 7'(TA_SLOT) : 7'(WR_LAST))) return {1'b1, f[5'(7'd63 - n)]};
    return 2'b00;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      slot    <= '0;
      rd      <= 1'b0;
      frame   <= '0;
      rx      <= '0;
      rdata   <= '0;
      done    <= 1'b0;
      mdc     <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          rd      <= op_read;
          frame   <= frame_in;
          slot    <= '0;
          cnt     <= '0;
          mdc     <= 1'b0;
          mdio_oe <= 1'b1;
          mdio_o  <= 1'b1;
          st      <= S_LOW;
        end
        S_LOW: begin
          if (half_up) begin
            cnt <= '0;
            mdc <= 1'b1;
            st  <= S_HIGH;
          end else cnt <= cnt + CW'(1);
        end
        S_HIGH: begin
          if (cnt == '0 && cap_win) rx <= {rx[14:0], mdio_i};
          if (half_up) begin
            cnt <= '0;
            mdc <= 1'b0;
            if (slot == last) begin
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b0;
              if (rd) st <= S_END;
              else begin
                st   <= S_IDLE;
                done <= 1'b1;
              end
            end else begin
              slot              <= nslot;
              {mdio_oe, mdio_o} <= drive(nslot, rd, frame);
              st                <= S_LOW;
            end
          end else cnt <= cnt + CW'(1);
        end
        default: begin
          if (half_up) begin
            cnt   <= '0;
            done  <= 1'b1;
            rdata <= rx;
            st    <= S_IDLE;
          end else cnt <= cnt + CW'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/mdio_master_sva.sv
module mdio_master_sva #(
  parameter int HALF_CLKS = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rdata
);
  int hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !mdc) hi_cnt <= 0;
    else             hi_cnt <= hi_cnt + 1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!mdc && !mdio_oe && !busy && !done && rdata == 16'h0));

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdio_oe && !mdc));

  assert_drive_stable_high_R8: assert property (@(posedge clk) disable iff (rst)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_start_taken_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_high_phase_R11: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= HALF_CLKS);

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata) |-> done);
endmodule

bind mdio_master mdio_master_sva #(.HALF_CLKS(HALF_CLKS)) u_sva (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rdata(rdata)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op_read = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wdata = '0;
  logic        mdio_i = 1'b1;
  logic [15:0] rdata;
  logic        done, busy, mdc, mdio_o, mdio_oe;

  mdio_master #(.HALF_CLKS(H)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op_read(op_read),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
    .rdata(rdata), .done(done), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic cap_o [0:79];
  logic cap_oe[0:79];
  logic phy_v [0:79];
  int rises = 0;
  int cyc = 0, fall_cyc = 0, done_cyc = 0, done_cnt = 0, busy_cyc = 0;
  int hi_run = 0, hp_err = 0, phase_err = 0;
  logic prev_mdc = 1'b0;

  always @(posedge mdc) begin
    if (rises < 80) begin
      cap_o[rises]  = mdio_o;
      cap_oe[rises] = mdio_oe;
    end
    rises = rises + 1;
  end

  always @(negedge mdc) mdio_i = phy_v[(rises < 80) ? rises : 79];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (busy) busy_cyc = busy_cyc + 1;
    if (done) begin done_cnt = done_cnt + 1; done_cyc = cyc; end
    if (prev_mdc && !mdc) begin
      fall_cyc = cyc;
      if (hi_run != H) hp_err = hp_err + 1;
    end
    if (mdc) hi_run = hi_run + 1; else hi_run = 0;
    if (mdc && rises > 0 && rises <= 80)
      if (mdio_o !== cap_o[rises-1] || mdio_oe !== cap_oe[rises-1]) phase_err = phase_err + 1;
    prev_mdc = mdc;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] pv, input bit junk);
    logic [13:0] hdr;
    logic [15:0] old_rdata;
    int pre_err, hdr_err, tail_err;
    hdr = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
    for (int k = 0; k < 80; k++) phy_v[k] = 1'b1;
    if (rd) begin
      phy_v[47] = 1'b0;
      for (int i = 0; i < 16; i++) phy_v[48+i] = pv[15-i];
    end else phy_v[64] = ~rdata[0];
    old_rdata = rdata;
    @(negedge clk);
    rises = 0; done_cnt = 0; busy_cyc = 0; hp_err = 0; phase_err = 0;
    start = 1'b1; op_read = rd; phy_addr = pa; reg_addr = ra; wdata = wd;
    @(negedge clk);
    start = 1'b0;
    if (junk) begin
      repeat (40) @(negedge clk);
      start = 1'b1; op_read = ~rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (10 * H) @(negedge clk);
    pre_err = 0; hdr_err = 0; tail_err = 0;
    for (int k = 0; k < 32; k++)
      if (cap_oe[k] !== 1'b1 || cap_o[k] !== 1'b1) pre_err++;
    for (int k = 32; k < 46; k++)
      if (cap_oe[k] !== 1'b1 || cap_o[k] !== hdr[45-k]) hdr_err++;
    check(pre_err == 0, "R2 preamble bits wrong", pre_err, 0);
    check(hdr_err == 0, "R3 header bits wrong", hdr_err, 0);
    if (rd) begin
      for (int k = 46; k < 67; k++) if (cap_oe[k] !== 1'b0) tail_err++;
      check(tail_err == 0, "R5 line not released", tail_err, 0);
      check(rdata == pv, "R5 read data", rdata, pv);
      check(rises == 67, "R6 read rise count", rises, 67);
      check(done_cyc - fall_cyc == H, "R6 end phase length", done_cyc - fall_cyc, H);
      check(busy_cyc == 135 * H, "R10 read busy length", busy_cyc, 135 * H);
    end else begin
      if (cap_oe[46] !== 1'b1 || cap_o[46] !== 1'b1) tail_err++;
      if (cap_oe[47] !== 1'b1 || cap_o[47] !== 1'b0) tail_err++;
      for (int k = 48; k < 64; k++)
        if (cap_oe[k] !== 1'b1 || cap_o[k] !== wd[63-k]) tail_err++;
      check(tail_err == 0, "R4 turnaround/data bits wrong", tail_err, 0);
      check(cap_oe[64] === 1'b0, "R7 last clock released", int'(cap_oe[64]), 0);
      check(rises == 65, "R7 write rise count", rises, 65);
      check(done_cyc == fall_cyc, "R7 done at last fall", done_cyc - fall_cyc, 0);
      check(rdata == old_rdata, "R7 rdata untouched by write", rdata, old_rdata);
      check(busy_cyc == 130 * H, "R10 write busy length", busy_cyc, 130 * H);
    end
    check(done_cnt == 1, junk ? "R9 extra frame after ignored start" : "R10 done pulse count", done_cnt, 1);
    check(phase_err == 0, "R8 drive changed while MDC high", phase_err, 0);
    check(hp_err == 0, "R11 MDC high phase length", hp_err, 0);
    check(!busy && !mdc && !mdio_oe, "R1 idle after frame", {busy, mdc, mdio_oe}, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(mdc == 1'b0, "R1 mdc in reset", mdc, 0);
    check(mdio_oe == 1'b0, "R1 oe in reset", mdio_oe, 0);
    check(!busy && !done, "R1 busy/done in reset", {busy, done}, 0);
    check(rdata == 16'h0, "R1 rdata in reset", rdata, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !mdc, "R1 idle after reset", {busy, mdc}, 0);
  endtask

  task automatic t_hold();
    logic [15:0] keep;
    keep = rdata;
    repeat (50) @(negedge clk);
    check(rdata == keep, "R12 rdata held while idle", rdata, keep);
  endtask

  initial begin
    for (int k = 0; k < 80; k++) phy_v[k] = 1'b1;
    t_reset();
    run_frame(1'b0, 5'h12, 5'h05, 16'hBEEF, 16'h0, 1'b0);
    run_frame(1'b1, 5'h01, 5'h1E, 16'h0, 16'hA5C3, 1'b0);
    t_hold();
    run_frame(1'b0, 5'h00, 5'h1F, 16'hFFFF, 16'h0, 1'b0);
    t_hold();
    run_frame(1'b1, 5'h1F, 5'h00, 16'h0, 16'h0001, 1'b0);
    run_frame(1'b0, 5'h0A, 5'h15, 16'h8001, 16'h0, 1'b1);
    run_frame(1'b1, 5'h15, 5'h0A, 16'h0, 16'hFFFF, 1'b1);
    run_frame(1'b1, 5'h03, 5'h11, 16'h0, 16'h0000, 1'b0);
    t_hold();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule